// File: doc/BRIEF.md
# SDRAM Controller with Refresh Scheduler

This block sits between a simple host request port and a two-bank single-data-rate SDRAM. The memory has 11 row address bits and 8 column address bits. The host presents one word at a time on a valid/ready port, carrying a flat word address, a write flag and the write data. The controller turns each request into a closed-page access. It opens the row, issues a read or write with auto-precharge, and then waits until the bank may be opened again. Read results return on a one-cycle data-valid pulse.

Every device timing limit is given in picoseconds together with the clock period. The controller rounds each limit up to whole clocks at elaboration time. After reset it waits a programmable power-up time. It then closes all banks, runs two refresh cycles and writes the mode register. Only after that does it accept host traffic. A free-running interval counter requests an auto refresh at the rate needed for 2048 refreshes per 32 ms. The pending refresh is served between host transactions, ahead of any waiting request.

Top module: `sdram_ctrl`

## Requirements
- R1: From reset release, the device stays deselected for INIT = ceil(INIT_NS*1000/CLK_PS) cycles, with `sd_cs_n`=1, `sd_dqm`=1 and `req_ready`=0. The command in cycle INIT+1 is precharge-all.
- R2: Start-up order is precharge-all with `sd_addr[10]`=1, then exactly two auto refreshes, then the mode register write. No activate, read or write comes before the mode write. `req_ready` stays low until 2 cycles after it.
- R3: The mode word on `sd_addr` sets burst length 1 (bits 2:0 = 000) and sequential order (bit 3 = 0). Bits 6:4 carry CAS_LAT and every other bit is 0, with `sd_ba`=0.
- R4: Each wait is the picosecond limit divided by CLK_PS, rounded up. An activate is followed by its read or write no sooner than tRCD. The next activate of that bank comes no sooner than tRC and no sooner than tRAS+tRP after the previous one.
- R5: `req_addr[19]` is the bank, `req_addr[18:8]` the row and `req_addr[7:0]` the column. An activate drives the row on `sd_addr`. A read or write drives the column on `sd_addr[7:0]` with `sd_addr[10]`=1 (auto-precharge).
- R6: Write data is on `sd_dq_out`, with `sd_dq_oe`=1 and `sd_dqm`=0, only in the write command cycle. The next activate follows the write by at least 2 clocks plus tRP.
- R7: A read sampled at clock edge t makes the controller capture `sd_dq_in` at edge t+CAS_LAT. `rd_valid` is high for exactly the one cycle after that edge, with that word on `rd_data`.
- R8: A refresh is requested every floor(REFI_NS*1000/CLK_PS) cycles. A pending refresh is issued from idle before any new request. Consecutive refreshes are never further apart than that interval plus one host transaction.
- R9: A refresh is issued only while both banks are closed. No other command follows it within tRC.
- R10: After a mode register write, at least 2 clocks pass before the next command.
- R11: One request is taken per cycle with `req_valid` and `req_ready` both high. Its activate is issued in the very next cycle, and `req_ready` stays low until that access has finished.
- R12: Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as follows: deselect 1xxx, no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode write 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 16 | Returned read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 11 | Multiplexed row/column address; bit 10 is auto-precharge / all-banks |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 16 | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data returned by the memory |

## Verification
The assertions assume the host holds `req_write`, `req_addr` and `req_wdata` steady while `req_valid` is high and not yet accepted. They also assume the memory puts read data on `sd_dq_in` exactly CAS_LAT edges after the read and holds it across the capturing edge. The bench changes host inputs only just after a rising edge and keeps them fixed until `req_ready` is seen. Its memory model drives `sd_dq_in` from the half cycle before the capture edge to the half cycle after it. The host keeps requests back-to-back for long stretches so that a refresh can only be served by taking priority over a waiting request.

// File: rtl/sdram_ctrl.sv
`timescale 1ns/1ps
module sdram_ctrl #(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int CLK_PS  = 4000,
  parameter int CAS_LAT = 3,
  parameter int TRCD_PS = 18000,
  parameter int TRP_PS  = 18000,
  parameter int TRAS_PS = 42000,
  parameter int TRC_PS  = 60000,
  parameter int TRDL_CK = 2,
  parameter int TMRD_CK = 2,
  parameter int REFI_NS = 15625,
  parameter int INIT_NS = 200000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W:0]     req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic                     sd_ba,
  output logic [ROW_W-1:0]         sd_addr,
  output logic                     sd_dqm,
  output logic [DATA_W-1:0]        sd_dq_out,
  output logic                     sd_dq_oe,
  input  logic [DATA_W-1:0]        sd_dq_in
);

  function automatic int ck_up(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int at2(input int v);
    return (v < 2) ? 2 : v;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_RCD   = ck_up(TRCD_PS);
  localparam int T_RP    = ck_up(TRP_PS);
  localparam int T_RAS   = ck_up(TRAS_PS);
  localparam int T_RC    = ck_up(TRC_PS);
  localparam int G_RCD   = at2(T_RCD);
  localparam int G_RP    = at2(T_RP);
  localparam int G_RC    = at2(T_RC);
  localparam int G_MRD   = at2(TMRD_CK);
  localparam int G_BASE  = mx(T_RC - T_RCD, T_RAS - T_RCD + T_RP);
  localparam int G_RD    = at2(mx(G_BASE, CAS_LAT + T_RP));
  localparam int G_WR    = at2(mx(G_BASE, TRDL_CK + T_RP));
  localparam int REFI_CK = mx((REFI_NS * 1000) / CLK_PS, 2);
  localparam int INIT_CK = mx(ck_up(INIT_NS * 1000), 1);
  localparam int CNT_W   = $clog2(mx(INIT_CK, 64)) + 1;
  localparam int RF_W    = $clog2(REFI_CK + 1) + 1;
  localparam int AP      = 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;

  localparam logic [3:0] C_DSL = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [3:0] {
    S_PWR, S_PALL, S_REF1, S_REF2, S_MRS, S_IDLE, S_ACT, S_RW, S_WAIT
  } st_t;

  st_t                st, nxt;
  logic [CNT_W-1:0]   cnt;
  logic [RF_W-1:0]    ref_cnt;
  logic               ref_pend;
  logic               live;
  logic               r_we, r_bank;
  logic [ROW_W-1:0]   r_row;
  logic [COL_W-1:0]   r_col;
  logic [DATA_W-1:0]  r_wdata;
  logic [CAS_LAT-1:0] rd_pipe;
  logic [3:0]         cmd;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign sd_dqm    = !live;
  assign sd_dq_oe  = (st == S_RW) && r_we;
  assign sd_dq_out = r_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PWR;
      nxt      <= S_IDLE;
      cnt      <= CNT_W'(INIT_CK - 1);
      ref_cnt  <= RF_W'(REFI_CK - 1);
      ref_pend <= 1'b0;
      live     <= 1'b0;
      r_we     <= 1'b0;
      r_bank   <= 1'b0;
      r_row    <= '0;
      r_col    <= '0;
      r_wdata  <= '0;
      rd_pipe  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[CAS_LAT-2:0], (st == S_RW) && !r_we};
      rd_valid <= rd_pipe[CAS_LAT-1];
      if (rd_pipe[CAS_LAT-1]) rd_data <= sd_dq_in;

      if (st == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (ref_cnt == '0) begin
        ref_cnt  <= RF_W'(REFI_CK - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end

      case (st)
        S_PWR: begin
          if (cnt == '0) st <= S_PALL;
          else cnt <= cnt - 1'b1;
        end
        S_PALL: begin cnt <= CNT_W'(G_RP - 2); nxt <= S_REF1; st <= S_WAIT; end
        S_REF1: begin cnt <= CNT_W'(G_RC - 2); nxt <= S_REF2; st <= S_WAIT; end
        S_REF2: begin cnt <= CNT_W'(G_RC - 2); nxt <= S_MRS;  st <= S_WAIT; end
        S_MRS: begin
          cnt  <= CNT_W'(G_MRD - 2);
          nxt  <= S_IDLE;
          st   <= S_WAIT;
          live <= 1'b1;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cnt <= CNT_W'(G_RC - 2);
            nxt <= S_IDLE;
            st  <= S_WAIT;
          end else if (req_valid) begin
            r_we    <= req_write;
            r_bank  <= req_addr[ROW_W+COL_W];
            r_row   <= req_addr[COL_W +: ROW_W];
            r_col   <= req_addr[COL_W-1:0];
            r_wdata <= req_wdata;
            st      <= S_ACT;
          end
        end
        S_ACT: begin cnt <= CNT_W'(G_RCD - 2); nxt <= S_RW; st <= S_WAIT; end
        S_RW: begin
          cnt <= r_we ? CNT_W'(G_WR - 2) : CNT_W'(G_RD - 2);
          nxt <= S_IDLE;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) st <= nxt;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_PWR;
      endcase
    end
  end

  always_comb begin
    cmd     = C_NOP;
    sd_ba   = 1'b0;
    sd_addr = '0;
    case (st)
      S_PWR:  cmd = C_DSL;
      S_PALL: begin cmd = C_PRE; sd_addr[AP] = 1'b1; end
      S_REF1, S_REF2: cmd = C_REF;
      S_MRS:  begin cmd = C_MRS; sd_addr = MODE_WORD; end
      S_IDLE: if (ref_pend) cmd = C_REF;
      S_ACT:  begin cmd = C_ACT; sd_ba = r_bank; sd_addr = r_row; end
      S_RW: begin
        cmd                  = r_we ? C_WR : C_RD;
        sd_ba                = r_bank;
        sd_addr[COL_W-1:0]   = r_col;
        sd_addr[AP]          = 1'b1;
      end
      default: cmd = C_NOP;
    endcase
  end

  // R1
  init_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !req_ready);
  // R11
  accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd == C_ACT));
  // R10
  mrs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS) |=> (cmd == C_NOP));
  // R9
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |=> (cmd == C_NOP));
  // R5
  auto_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> sd_addr[AP]);
  // R6
  wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == C_WR && !sd_dqm));
  // R7
  rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD) |-> ##(CAS_LAT + 1) rd_valid);

endmodule

// File: tb/sdram_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_ctrl_tb_top;
  localparam int CLKPS  = 4000;
  localparam int CL     = 3;
  localparam int TRCD_C = (18000 + CLKPS - 1) / CLKPS;
  localparam int TRP_C  = (18000 + CLKPS - 1) / CLKPS;
  localparam int TRAS_C = (42000 + CLKPS - 1) / CLKPS;
  localparam int TRC_C  = (60000 + CLKPS - 1) / CLKPS;
  localparam int REFI_C = 1200 * 1000 / CLKPS;
  localparam int INIT_C = (400 * 1000 + CLKPS - 1) / CLKPS;
  localparam int SLACK  = 40;

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                         K_MRS = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
  logic sd_dqm, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [15:0] sd_dq_in = 16'hDEAD;
  logic [10:0] sd_addr;

  always #2 clk = ~clk;

  sdram_ctrl #(.CLK_PS(CLKPS), .CAS_LAT(CL), .REFI_NS(1200), .INIT_NS(400)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int vec = 0, fails = 0, cyc = 0, k = 0;
  int last_ref = -100000, mrs_t = -100000, acc_t = -100000, nref_init = 0;
  bit pall_seen = 0, mrs_seen = 0;
  bit open_b[2];
  int row_b[2], act_t[2], rdy_t[2];
  logic [15:0] mem [int];
  logic [15:0] refm [int];
  logic [15:0] exp_q[$];
  int rv_t[$];
  int dq_t[$];
  logic [15:0] dq_v[$];
  bit pq_w[$];
  logic [19:0] pq_a[$];
  logic [15:0] pq_d[$];

  function automatic logic [15:0] dflt(input int key);
    return 16'(key * 7) ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    int t, key, b, ready_at;
    logic [3:0] c;
    bit ev;
    k++;
    t = cyc + 1;
    // R7: cycle-exact return of read data
    ev = (rv_t.size() > 0) && (rv_t[0] == cyc);
    chk(rd_valid == ev, "R7", "rd_valid timing", rd_valid, ev);
    if (ev) begin
      void'(rv_t.pop_front());
      if (exp_q.size() > 0) begin
        chk(rd_data == exp_q[0], "R7", "read data", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
      end else chk(0, "R7", "unexpected read return", rd_data, 0);
    end
    if (dq_t.size() > 0 && dq_t[0] == cyc) begin
      sd_dq_in = dq_v.pop_front();
      void'(dq_t.pop_front());
    end else sd_dq_in = 16'hDEAD;

    if (req_valid && req_ready) begin
      acc_t = t;
      pq_w.push_back(req_write);
      pq_a.push_back(req_addr);
      pq_d.push_back(req_wdata);
    end

    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (k <= INIT_C) begin
      chk(sd_cs_n == 1'b1, "R1", "deselect during power-up", sd_cs_n, 1);
      chk(sd_dqm == 1'b1, "R1", "mask during power-up", sd_dqm, 1);
    end
    if (k == INIT_C + 1)
      chk(c == K_PRE && sd_addr[10], "R1", "first command precharge-all", c, K_PRE);
    if (!mrs_seen || t < mrs_t + 2)
      chk(!req_ready, "R2", "ready before set-up done", req_ready, 0);
    chk(!sd_dq_oe || c == K_WR, "R6", "data driven outside write", c, K_WR);

    if (!sd_cs_n && c != K_NOP) begin
      b = sd_ba;
      case (c)
        K_PRE: begin
          chk(sd_addr[10], "R2", "precharge all banks", sd_addr[10], 1);
          pall_seen = 1;
          for (int i = 0; i < 2; i++) begin open_b[i] = 0; rdy_t[i] = t + TRP_C; end
        end
        K_REF: begin
          chk(!open_b[0] && !open_b[1] && t >= rdy_t[0] && t >= rdy_t[1],
              "R9", "refresh with banks closed", t, rdy_t[0]);
          chk(t - last_ref >= TRC_C, "R9", "refresh spacing", t - last_ref, TRC_C);
          chk(t - mrs_t >= 2, "R10", "gap after mode write", t - mrs_t, 2);
          if (!mrs_seen) begin
            chk(pall_seen, "R2", "refresh after precharge-all", pall_seen, 1);
            nref_init++;
          end else
            chk(t - last_ref <= REFI_C + SLACK, "R8", "refresh interval",
                t - last_ref, REFI_C + SLACK);
          last_ref = t;
        end
        K_MRS: begin
          chk(nref_init == 2, "R2", "two refreshes before mode write", nref_init, 2);
          chk(sd_addr == 11'(CL << 4) && !sd_ba, "R3", "mode word", sd_addr, CL << 4);
          chk(!open_b[0] && !open_b[1], "R2", "mode write with banks closed", 0, 0);
          mrs_seen = 1;
          mrs_t = t;
        end
        K_ACT: begin
          chk(mrs_seen, "R2", "activate after mode write", mrs_seen, 1);
          chk(!open_b[b] && t >= rdy_t[b], "R4", "activate spacing", t, rdy_t[b]);
          chk(t - last_ref >= TRC_C, "R9", "activate after refresh", t - last_ref, TRC_C);
          chk(t - mrs_t >= 2, "R10", "activate after mode write", t - mrs_t, 2);
          chk(t == acc_t + 1, "R11", "activate follows acceptance", t, acc_t + 1);
          if (pq_a.size() > 0) begin
            chk(b == pq_a[0][19], "R5", "bank select", b, pq_a[0][19]);
            chk(sd_addr == pq_a[0][18:8], "R5", "row address", sd_addr, pq_a[0][18:8]);
          end else chk(0, "R11", "activate without request", 1, 0);
          open_b[b] = 1; row_b[b] = sd_addr; act_t[b] = t;
        end
        K_RD, K_WR: begin
          chk(open_b[b], "R4", "column command to open bank", open_b[b], 1);
          chk(t - act_t[b] >= TRCD_C, "R4", "row to column delay", t - act_t[b], TRCD_C);
          chk(sd_addr[10] && sd_addr[9:8] == 2'b00, "R5", "auto-precharge column", sd_addr, 11'h400);
          key = (b << 19) | (row_b[b] << 8) | sd_addr[7:0];
          if (pq_a.size() > 0) begin
            chk(key == int'(pq_a[0]), "R5", "column address", key, pq_a[0]);
            chk((c == K_WR) == pq_w[0], "R11", "direction", c, pq_w[0]);
          end
          if (c == K_WR) begin
            chk(sd_dq_oe && !sd_dqm, "R6", "write drive", {sd_dq_oe, sd_dqm}, 2'b10);
            if (pq_d.size() > 0)
              chk(sd_dq_out == pq_d[0], "R6", "write data", sd_dq_out, pq_d[0]);
            mem[key] = sd_dq_out;
            ready_at = t + 2 + TRP_C;
          end else begin
            dq_t.push_back(t + CL - 1);
            dq_v.push_back(mem.exists(key) ? mem[key] : dflt(key));
            rv_t.push_back(t + CL);
            ready_at = t + 1 + TRP_C;
          end
          if (act_t[b] + TRC_C > ready_at) ready_at = act_t[b] + TRC_C;
          if (act_t[b] + TRAS_C + TRP_C > ready_at) ready_at = act_t[b] + TRAS_C + TRP_C;
          rdy_t[b] = ready_at;
          open_b[b] = 0;
          if (pq_a.size() > 0) begin
            void'(pq_a.pop_front()); void'(pq_w.pop_front()); void'(pq_d.pop_front());
          end
        end
        default: chk(0, "R12", "illegal command code", c, K_NOP);
      endcase
    end
  end

  task automatic host(input bit w, input logic [19:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    req_write = w; req_addr = a; req_wdata = d; req_valid = 1;
    if (w) refm[a] = d;
    else exp_q.push_back(refm.exists(a) ? refm[a] : dflt(int'(a)));
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic run_tests;
    logic [19:0] lf;
    logic [19:0] used[$];
    repeat (3) @(posedge clk);
    #1;
    // R1: state while held in reset
    chk(sd_cs_n && !req_ready && !rd_valid && sd_dqm, "R1", "reset outputs",
        {sd_cs_n, req_ready, rd_valid, sd_dqm}, 4'b1001);
    @(posedge clk); #1 rst_n = 1;
    host(1, 20'h00000, 16'h1111);
    host(1, 20'hFFFFF, 16'hBEEF);
    host(1, {1'b1, 11'd5, 8'd9}, 16'hAAAA);
    host(1, {1'b0, 11'd5, 8'd9}, 16'h5555);
    host(0, 20'h00000, 0);
    host(0, 20'hFFFFF, 0);
    host(0, {1'b1, 11'd5, 8'd9}, 0);
    host(0, {1'b0, 11'd5, 8'd9}, 0);
    host(0, 20'h12345, 0);
    host(1, 20'h00000, 16'h2222);
    host(0, 20'h00000, 0);
    host(0, 20'h00000, 0);
    lf = 20'h9A3C1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[18:0], lf[19] ^ lf[16]};
      if (i % 3 != 2) begin
        host(1, lf, lf[15:0] ^ 16'(i));
        used.push_back(lf);
      end else host(0, used[(i * 5) % used.size()], 0);
    end
    repeat (800) @(posedge clk);
    for (int i = 0; i < 6; i++) host(0, used[i], 0);
    while (exp_q.size() > 0) @(posedge clk);
    repeat (30) @(posedge clk);
    #1 chk(cyc + 1 - last_ref <= REFI_C + SLACK, "R8", "refresh still running",
           cyc + 1 - last_ref, REFI_C + SLACK);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule